// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block is a windowed watchdog for a chip subsystem. It sits on a simple word-wide register bus. Software fills in a preload value, a reaction choice and a window choice, then arms the watchdog with a fixed 32-bit magic value. From then on a down-counter runs from the preload value shifted left by a fixed amount. Software must service it with two key words written in the right order, and only while the count is inside the open window.

The watchdog reacts to three events: the count reaching zero, a key word that breaks the service sequence, and a correct sequence that lands outside the window. Each event sets its own sticky status bit and fires the selected reaction. The reaction is either a one-cycle non-maskable interrupt pulse or a reset request held for a fixed number of cycles. Once armed, the watchdog cannot be turned off or reconfigured except by the block reset.

Top module: `win_watchdog`

## Requirements
- R1: After reset, these offsets read 0: control (0x90), status (0x98) and counter (0xA0). The preload (0x94) reads 0xFFF, reaction (0xA4) reads 0x0 and window (0xA8) reads 0x05. Both reaction outputs are low.
- R2: Writing 0xA98559DA to control (0x90) arms the watchdog, and control then reads 0xA98559DA. Any other value written while disarmed leaves control reading 0. No later write disarms it; only the block reset does.
- R3: The preload register keeps the low 12 bits of a write. When the watchdog is armed, the counter loads preload << SHIFT, and the counter register at 0xA0 shows that value in the cycle after the arming write.
- R4: While armed, the counter falls by one each clock. In a cycle where it holds 0, it reloads preload << SHIFT, sets status bit 0 (expired) and fires the reaction.
- R5: A key write of 0x0000E51A to 0x9C followed by a key write of 0x0000A35C is a service. An accepted service reloads the counter with preload << SHIFT.
- R6: Any other key value, or 0x0000A35C without an immediately preceding 0x0000E51A, is a key violation. It sets status bit 1 and fires the reaction.
- R7: With window code 0x50 (written to 0xA8), a service is accepted only if the count is below (preload << SHIFT)/2 when the second key is written. At or above that value it is a window violation: status bit 2 sets, the reaction fires and the counter is not reloaded.
- R8: Any window code other than 0x50, including 0x05, opens the window over the whole count, so a service is accepted at any count.
- R9: Reaction code 0xA (low 4 bits at 0xA4) selects the interrupt. wdt_nmi is then high for exactly the one cycle after the event edge. Any other code selects reset: wdt_rst_req goes high after the event edge and stays high for RST_CYCLES (16) cycles.
- R10: Writing 1 to a status bit clears it. Writing 0 leaves it as it is.
- R11: While the watchdog is armed, writes to preload, reaction and window have no effect.
- R12: While the watchdog is disarmed, key writes have no effect: no status bit sets and no reaction fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the accessed word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| wdt_nmi | output | 1 | One-cycle interrupt pulse reaction |
| wdt_rst_req | output | 1 | Reset request reaction, RST_CYCLES long |

## Verification
Expiry is swept over six preload values in interrupt mode. Each run checks the count at arming, the zero count, the reload and the single pulse, which separates a wrong shift or an off-by-one in the expiry cycle. The half window is probed with the second key landing exactly on the half count and one below it, which separates a `<` from a `<=` compare. Key violations are driven with a foreign value and with a lone second key. A separate run in reset mode measures the held width of the reset request. Writes to the lock-protected registers and key writes while disarmed are followed by readback and a pulse count, to show that they were ignored.

// File: rtl/win_wdog_pkg.sv
// Shared constants for the windowed watchdog: register offsets and magic codes.
// Assumes a 32-bit register bus and byte offsets that fit in 8 bits.
package win_wdog_pkg;
    localparam int BUS_W = 32;

    localparam logic [7:0] OFS_CTRL    = 8'h90;
    localparam logic [7:0] OFS_PRELOAD = 8'h94;
    localparam logic [7:0] OFS_STATUS  = 8'h98;
    localparam logic [7:0] OFS_KEY     = 8'h9C;
    localparam logic [7:0] OFS_COUNT   = 8'hA0;
    localparam logic [7:0] OFS_REACT   = 8'hA4;
    localparam logic [7:0] OFS_WIN     = 8'hA8;

    localparam logic [BUS_W-1:0] ARM_CODE  = 32'hA98559DA;
    localparam logic [BUS_W-1:0] SVC_FIRST = 32'h0000E51A;
    localparam logic [BUS_W-1:0] SVC_LAST  = 32'h0000A35C;

    localparam logic [3:0] REACT_NMI = 4'hA;
    localparam logic [7:0] WIN_HALF  = 8'h50;
    localparam logic [7:0] WIN_FULL  = 8'h05;

    // Event flags in status bit order
    typedef struct packed {
        logic win_err;
        logic key_err;
        logic expired;
    } wdog_evt_t;
endpackage

// File: rtl/win_wdog_keyseq.sv
// Service key sequencer: checks the ordered two-word key pair.
// Assumes key_wr is a single-cycle strobe; it is only acted on while armed.
module win_wdog_keyseq
    import win_wdog_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             armed,
    input  logic             key_wr,
    input  logic [BUS_W-1:0] key_data,
    output logic             svc_req,
    output logic             key_err
);
    logic first_seen_q;
    logic is_first;
    logic is_last;

    // Decode the written word and classify the access
    always_comb begin
        is_first = (key_data == SVC_FIRST);
        is_last  = (key_data == SVC_LAST);
        svc_req  = armed && key_wr && first_seen_q && is_last;
        key_err  = armed && key_wr && !is_first && !(first_seen_q && is_last);
    end

    // Remember whether the last key write was the opening word
    always_ff @(posedge clk) begin
        if (!rst_n || !armed)
            first_seen_q <= 1'b0;
        else if (key_wr)
            first_seen_q <= is_first;
    end
endmodule

// File: rtl/win_wdog_counter.sv
// Down-counter with reload, expiry detect and window check for services.
// Assumes preload is stable while armed (the register file locks it).
module win_wdog_counter #(
    parameter int PRELOAD_W = 12,
    parameter int SHIFT     = 13
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start,
    input  logic                         armed,
    input  logic                         svc_req,
    input  logic                         half_win,
    input  logic [PRELOAD_W-1:0]         preload,
    output logic [PRELOAD_W+SHIFT-1:0]   count,
    output logic                         expired,
    output logic                         svc_ok,
    output logic                         win_err
);
    localparam int CNT_W = PRELOAD_W + SHIFT;

    logic [CNT_W-1:0] reload;
    logic [CNT_W-1:0] half;
    logic             in_window;

    // Derive reload and window threshold, classify a service request
    always_comb begin
        reload    = {preload, {SHIFT{1'b0}}};
        half      = reload >> 1;
        in_window = !half_win || (count < half);
        svc_ok    = svc_req && in_window;
        win_err   = svc_req && !in_window;
        expired   = armed && (count == '0);
    end

    // Count down while armed, reload on arm, good service or expiry
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (start || svc_ok || expired)
            count <= reload;
        else if (armed)
            count <= count - CNT_W'(1);
    end
endmodule

// File: rtl/win_wdog_react.sv
// Reaction stage: a one-cycle interrupt pulse or a held reset request.
// Assumes nmi_mode is stable while events can occur.
module win_wdog_react #(
    parameter int RST_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trigger,
    input  logic nmi_mode,
    output logic nmi,
    output logic rst_req
);
    localparam int RC_W = $clog2(RST_CYCLES + 1);

    logic [RC_W-1:0] hold_q;

    // Register the interrupt pulse and run the reset-hold counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nmi    <= 1'b0;
            hold_q <= '0;
        end else begin
            nmi <= trigger && nmi_mode;
            if (trigger && !nmi_mode)
                hold_q <= RC_W'(RST_CYCLES);
            else if (hold_q != '0)
                hold_q <= hold_q - RC_W'(1);
        end
    end

    // Reset request is high while the hold counter runs
    always_comb rst_req = (hold_q != '0);
endmodule

// File: rtl/win_watchdog.sv
// Windowed watchdog top: register file, arming, status and submodule wiring.
// Assumes single-cycle bus accesses; reads are combinational and side-effect free.
module win_watchdog
    import win_wdog_pkg::*;
#(
    parameter int PRELOAD_W  = 12,
    parameter int SHIFT      = 13,
    parameter int RST_CYCLES = 16,
    parameter int ADDR_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              wdt_nmi,
    output logic              wdt_rst_req
);
    localparam int CNT_W = PRELOAD_W + SHIFT;

    logic                 en_q;
    logic [PRELOAD_W-1:0] preload_q;
    logic [3:0]           react_q;
    logic [7:0]           win_q;
    logic [2:0]           status_q;
    logic [CNT_W-1:0]     count;
    logic                 wr_ctrl, wr_pre, wr_stat, wr_key, wr_react, wr_win;
    logic                 start, svc_req, svc_ok;
    wdog_evt_t            evt;

    // Decode bus writes per register
    always_comb begin
        wr_ctrl  = bus_en && bus_we && (bus_addr == ADDR_W'(OFS_CTRL));
        wr_pre   = bus_en && bus_we && (bus_addr == ADDR_W'(OFS_PRELOAD));
        wr_stat  = bus_en && bus_we && (bus_addr == ADDR_W'(OFS_STATUS));
        wr_key   = bus_en && bus_we && (bus_addr == ADDR_W'(OFS_KEY));
        wr_react = bus_en && bus_we && (bus_addr == ADDR_W'(OFS_REACT));
        wr_win   = bus_en && bus_we && (bus_addr == ADDR_W'(OFS_WIN));
        start    = wr_ctrl && !en_q && (bus_wdata == ARM_CODE);
    end

    // One-way arm flag and configuration registers locked once armed
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q      <= 1'b0;
            preload_q <= '1;
            react_q   <= '0;
            win_q     <= WIN_FULL;
        end else begin
            if (start)
                en_q <= 1'b1;
            if (wr_pre && !en_q)
                preload_q <= bus_wdata[PRELOAD_W-1:0];
            if (wr_react && !en_q)
                react_q <= bus_wdata[3:0];
            if (wr_win && !en_q)
                win_q <= bus_wdata[7:0];
        end
    end

    // Sticky event flags, write-one-to-clear, a new event wins
    always_ff @(posedge clk) begin
        if (!rst_n)
            status_q <= '0;
        else
            status_q <= (status_q & ~(wr_stat ? bus_wdata[2:0] : 3'b000)) | evt;
    end

    win_wdog_keyseq u_keyseq (
        .clk      (clk),
        .rst_n    (rst_n),
        .armed    (en_q),
        .key_wr   (wr_key),
        .key_data (bus_wdata),
        .svc_req  (svc_req),
        .key_err  (evt.key_err)
    );

    win_wdog_counter #(
        .PRELOAD_W (PRELOAD_W),
        .SHIFT     (SHIFT)
    ) u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .armed    (en_q),
        .svc_req  (svc_req),
        .half_win (win_q == WIN_HALF),
        .preload  (preload_q),
        .count    (count),
        .expired  (evt.expired),
        .svc_ok   (svc_ok),
        .win_err  (evt.win_err)
    );

    win_wdog_react #(
        .RST_CYCLES (RST_CYCLES)
    ) u_react (
        .clk      (clk),
        .rst_n    (rst_n),
        .trigger  (|evt),
        .nmi_mode (react_q == REACT_NMI),
        .nmi      (wdt_nmi),
        .rst_req  (wdt_rst_req)
    );

    // Combinational read mux
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(OFS_CTRL))         bus_rdata = en_q ? ARM_CODE : '0;
        else if (bus_addr == ADDR_W'(OFS_PRELOAD)) bus_rdata = BUS_W'(preload_q);
        else if (bus_addr == ADDR_W'(OFS_STATUS))  bus_rdata = BUS_W'(status_q);
        else if (bus_addr == ADDR_W'(OFS_COUNT))   bus_rdata = BUS_W'(count);
        else if (bus_addr == ADDR_W'(OFS_REACT))   bus_rdata = BUS_W'(react_q);
        else if (bus_addr == ADDR_W'(OFS_WIN))     bus_rdata = BUS_W'(win_q);
    end
endmodule

// File: rtl/win_watchdog_chk.sv
// Property checker for the windowed watchdog, bound into every instance.
// Assumes it observes internal state of the top through the bind below.
module win_watchdog_chk #(
    parameter int PRELOAD_W = 12,
    parameter int SHIFT     = 13
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       en_q,
    input logic [PRELOAD_W-1:0]       preload_q,
    input logic [3:0]                 react_q,
    input logic [7:0]                 win_q,
    input logic [2:0]                 status_q,
    input logic [PRELOAD_W+SHIFT-1:0] count,
    input logic                       svc_ok,
    input logic                       wdt_nmi,
    input logic                       wdt_rst_req
);
    localparam int CNT_W = PRELOAD_W + SHIFT;

    logic [CNT_W-1:0] exp_reload;
    always_comb exp_reload = CNT_W'(preload_q) << SHIFT;

    p_enable_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        en_q |=> en_q);

    p_expire_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && count == '0) |=> (status_q[0] && count == exp_reload));

    p_service_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
        svc_ok |=> (count == exp_reload));

    p_window_open_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_ok && win_q == 8'h50) |-> (count < (exp_reload >> 1)));

    p_nmi_mode_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_nmi |-> (react_q == 4'hA));

    p_rst_mode_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_rst_req |-> (react_q != 4'hA));

    p_config_locked_r11: assert property (@(posedge clk) disable iff (!rst_n)
        en_q |=> ($stable(preload_q) && $stable(react_q) && $stable(win_q)));

    p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |=> (!wdt_nmi && status_q == '0 || $past(status_q) != '0));
endmodule

bind win_watchdog win_watchdog_chk #(
    .PRELOAD_W (PRELOAD_W),
    .SHIFT     (SHIFT)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .en_q        (en_q),
    .preload_q   (preload_q),
    .react_q     (react_q),
    .win_q       (win_q),
    .status_q    (status_q),
    .count       (count),
    .svc_ok      (svc_ok),
    .wdt_nmi     (wdt_nmi),
    .wdt_rst_req (wdt_rst_req)
);

// File: tb/win_watchdog_tb.sv
// Self-checking bench for the windowed watchdog, small shift for short runs.
module win_watchdog_tb;
    localparam int PW    = 12;
    localparam int SH    = 3;
    localparam int RSTC  = 16;

    localparam logic [7:0] A_CTRL = 8'h90, A_PRE = 8'h94, A_STAT = 8'h98, A_KEY = 8'h9C;
    localparam logic [7:0] A_CNT = 8'hA0, A_REACT = 8'hA4, A_WIN = 8'hA8;
    localparam logic [31:0] ARM = 32'hA98559DA, K1 = 32'h0000E51A, K2 = 32'h0000A35C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        wdt_nmi;
    logic        wdt_rst_req;

    int n_chk = 0;
    int n_fail = 0;
    int nmi_seen = 0;
    bit done = 0;

    always #4 clk = ~clk;

    win_watchdog #(.PRELOAD_W(PW), .SHIFT(SH), .RST_CYCLES(RSTC), .ADDR_W(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wdt_nmi(wdt_nmi), .wdt_rst_req(wdt_rst_req)
    );

    // Count interrupt pulses, sampled away from the active edge
    always @(negedge clk) if (rst_n && wdt_nmi) nmi_seen++;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_en = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        bus_en = 1'b0; bus_we = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Second key lands when the pre-edge count equals t
    task automatic service_at(input int t);
        logic [31:0] c;
        rd(A_CNT, c);
        wr(A_KEY, K1);
        repeat (int'(c) - 3 - t) @(negedge clk);
        wr(A_KEY, K2);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run hung, got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int base;
        do_reset();
        // R1 reset state
        rd(A_CTRL, v);  chk("R1 control", v, 0);
        rd(A_STAT, v);  chk("R1 status", v, 0);
        rd(A_CNT, v);   chk("R1 counter", v, 0);
        rd(A_PRE, v);   chk("R1 preload", v, 32'hFFF);
        rd(A_REACT, v); chk("R1 reaction", v, 0);
        rd(A_WIN, v);   chk("R1 window", v, 32'h05);
        chk("R1 outputs", {30'd0, wdt_nmi, wdt_rst_req}, 0);

        // R12 key writes while disarmed, R2 wrong arm value
        base = nmi_seen;
        wr(A_CTRL, 32'h12345678);
        rd(A_CTRL, v); chk("R2 wrong arm value", v, 0);
        wr(A_KEY, K1); wr(A_KEY, K2); wr(A_KEY, 32'hBEEF); wr(A_KEY, K2);
        @(negedge clk);
        rd(A_STAT, v); chk("R12 status untouched", v, 0);
        chk("R12 no reaction", {31'd0, wdt_rst_req}, 0);
        chk("R12 no pulse", nmi_seen - base, 0);

        // R3 preload keeps 12 bits
        wr(A_PRE, 32'hFFFFF);
        rd(A_PRE, v); chk("R3 preload mask", v, 32'hFFF);

        // R4 expiry sweep in interrupt mode
        for (int p = 1; p <= 6; p++) begin
            int r;
            r = p << SH;
            do_reset();
            wr(A_PRE, p); wr(A_REACT, 32'hA); wr(A_CTRL, ARM);
            rd(A_CNT, v);  chk("R3 load on arm", v, r);
            rd(A_CTRL, v); chk("R2 control reads key", v, ARM);
            repeat (r) @(negedge clk);
            rd(A_CNT, v); chk("R4 count reaches zero", v, 0);
            chk("R4 no early pulse", {31'd0, wdt_nmi}, 0);
            @(negedge clk);
            chk("R9 pulse after expiry", {31'd0, wdt_nmi}, 1);
            rd(A_CNT, v);  chk("R4 reload on expiry", v, r);
            rd(A_STAT, v); chk("R4 expired bit", v, 1);
            @(negedge clk);
            chk("R9 single-cycle pulse", {31'd0, wdt_nmi}, 0);
        end

        // R11 lock, R2 no disarm, R5/R8 full-window service at high count
        do_reset();
        wr(A_PRE, 5); wr(A_REACT, 32'hA); wr(A_WIN, 32'h05); wr(A_CTRL, ARM);
        wr(A_PRE, 9); wr(A_REACT, 0); wr(A_WIN, 32'h50); wr(A_CTRL, 0);
        rd(A_PRE, v);   chk("R11 preload locked", v, 5);
        rd(A_REACT, v); chk("R11 reaction locked", v, 32'hA);
        rd(A_WIN, v);   chk("R11 window locked", v, 32'h05);
        rd(A_CTRL, v);  chk("R2 still armed", v, ARM);
        base = nmi_seen;
        wr(A_KEY, K1); wr(A_KEY, K2);
        rd(A_CNT, v); chk("R5 service reloads", v, 40);
        @(negedge clk);
        chk("R8 no violation full window", nmi_seen - base, 0);

        // R6 key violations, R10 write-one-to-clear
        wr(A_KEY, 32'h1234);
        chk("R6 foreign key pulse", {31'd0, wdt_nmi}, 1);
        rd(A_STAT, v); chk("R6 key bit", v, 2);
        wr(A_STAT, 1);
        rd(A_STAT, v); chk("R10 writing 0 keeps bit", v, 2);
        wr(A_STAT, 2);
        rd(A_STAT, v); chk("R10 clear by 1", v, 0);
        wr(A_KEY, K2);
        chk("R6 lone second key pulse", {31'd0, wdt_nmi}, 1);
        rd(A_STAT, v); chk("R6 lone second key bit", v, 2);

        // R8 other window code is full window
        do_reset();
        wr(A_PRE, 5); wr(A_REACT, 32'hA); wr(A_WIN, 32'h33); wr(A_CTRL, ARM);
        wr(A_KEY, K1); wr(A_KEY, K2);
        rd(A_CNT, v);  chk("R8 code 0x33 accepts", v, 40);
        rd(A_STAT, v); chk("R8 code 0x33 no flag", v, 0);

        // R7 half window boundary: count 16 rejected, 15 accepted (reload 32)
        do_reset();
        wr(A_PRE, 4); wr(A_REACT, 32'hA); wr(A_WIN, 32'h50); wr(A_CTRL, ARM);
        service_at(16);
        chk("R7 at half pulse", {31'd0, wdt_nmi}, 1);
        rd(A_STAT, v); chk("R7 window bit", v, 4);
        rd(A_CNT, v);  chk("R7 no reload on violation", v, 15);
        do_reset();
        wr(A_PRE, 4); wr(A_REACT, 32'hA); wr(A_WIN, 32'h50); wr(A_CTRL, ARM);
        service_at(15);
        chk("R7 below half no pulse", {31'd0, wdt_nmi}, 0);
        rd(A_STAT, v); chk("R7 below half no flag", v, 0);
        rd(A_CNT, v);  chk("R7 below half reloads", v, 32);

        // R9 reset mode hold length
        do_reset();
        wr(A_PRE, 4); wr(A_REACT, 0); wr(A_WIN, 32'h50); wr(A_CTRL, ARM);
        base = nmi_seen;
        service_at(20);
        begin
            int hi;
            hi = wdt_rst_req ? 1 : 0;
            for (int i = 0; i < 40; i++) begin
                @(negedge clk);
                if (!wdt_rst_req) break;
                hi++;
            end
            chk("R9 reset hold cycles", hi, RSTC);
        end
        chk("R9 no pulse in reset mode", nmi_seen - base, 0);
        rd(A_STAT, v); chk("R7 window bit reset mode", v, 4);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule